// File: doc/BRIEF.md
# Inclusive Directory Snoop Filter

This block is the coherence directory that sits beside an inclusive shared last-level cache in a four-core cluster. Rather than broadcasting every coherence request, it records, for each block it tracks, a tag, a two-bit coherence state (Invalid, Shared, Modified) and one presence bit per core. Cores send it read misses, write misses, upgrade requests (a write to a block they hold Shared) and eviction notices. For each request it issues exactly one response. The response says whether the shared cache answers the requester directly or whether the request is forwarded to the single Modified owner. It also carries a bit-mask of the other cores that must receive a message.

The directory is set-indexed: the low address bits select an entry and the remaining bits form the tag. Because the cache is inclusive, every privately cached block must own an entry. When a new block takes an entry that another live block holds, every holder of the displaced block is named in a back-invalidation mask. Requests are handled one at a time. A `busy` flag guards acceptance, and a forwarded request holds the directory busy until the owning core acknowledges.

Top module: `snoopdir`

## Requirements
- R1: A read (op 0) to a block that is untracked or Shared returns kind GRANT_S (0) with an empty destination mask, and adds the requester to the block's presence vector.
- R2: A read to a block held Modified by another core returns kind FWD_RD (2) with the owner as the only destination bit. The directory stays busy until `ackValid`, after which the block is Shared with both the old owner and the requester present.
- R3: A write miss (op 1) or upgrade (op 2) to a Shared or untracked block returns kind GRANT_M (1). Its destination mask is the set of tracked sharers other than the requester, and afterwards the requester alone holds the block Modified.
- R4: A write miss or upgrade to a block held Modified by another core returns kind FWD_WR (3) to that owner only. After the acknowledge the requester is the sole Modified holder.
- R5: Any request from the core that already owns the block Modified returns GRANT_M with an empty destination mask and leaves the entry unchanged.
- R6: An eviction notice (op 3) returns kind DONE (4) with empty masks and clears the requester's presence bit. When no bit remains, the block becomes untracked, and a later block mapping to that entry displaces nothing.
- R7: An eviction notice for a block the directory does not track changes no entry.
- R8: A read, write or upgrade whose address maps to an entry holding a different live block reports every holder of that block in `rspVictim`. The new block replaces it.
- R9: A request is accepted on a rising edge where `reqValid` is high and `busy` is low. `busy` is high from the next edge. The response is a one-cycle `rspValid` pulse registered on the second edge after acceptance, and requests presented while busy are ignored.
- R10: No destination mask ever includes the requester (`rspCore`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqCore | input | 2 | Requesting core number |
| reqOp | input | 2 | 0 read, 1 write miss, 2 upgrade, 3 eviction notice |
| reqAddr | input | 10 | Block address (low 3 bits index, upper 7 bits tag) |
| ackValid | input | 1 | Acknowledge from a forwarded-to owner |
| busy | output | 1 | Directory is processing a request |
| rspValid | output | 1 | Response pulse |
| rspKind | output | 3 | 0 GRANT_S, 1 GRANT_M, 2 FWD_RD, 3 FWD_WR, 4 DONE |
| rspCore | output | 2 | Requester the response belongs to |
| rspDest | output | 4 | Other cores to message (invalidate or forward) |
| rspVictim | output | 4 | Holders of a displaced block to back-invalidate |

## Verification
The bench drives a block through growing sharer sets and then upgrades it. This exposes a design that puts the requester in its own invalidation mask, or that leaves stale sharers present after ownership moves. Forwards to a Modified owner are held for several cycles while stray requests arrive. A design that does not block on the acknowledge, or that accepts those requests, would emit extra responses or corrupt the entry. Entry conflicts, owner re-requests and evictions of tracked and untracked blocks are also exercised. A wrong design would miss back-invalidations, send needless messages, or keep a dead entry that later shows up as a spurious victim.

// File: rtl/snoopdir_pkg.sv
package snoopdir_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_UPGRADE = 2'd2,
    OP_EVICT   = 2'd3
  } opE;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } stE;

  typedef enum logic [2:0] {
    RK_GRANT_S = 3'd0,
    RK_GRANT_M = 3'd1,
    RK_FWD_RD  = 3'd2,
    RK_FWD_WR  = 3'd3,
    RK_DONE    = 3'd4
  } rkE;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchReq;
    logic lookupCommit;
    logic ackCommit;
  } strobeT;

endpackage

// File: rtl/snoopdir_ctrl.sv
module snoopdir_ctrl
  import snoopdir_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   needFwd,
  input  logic   ackValid,
  output strobeT strobe,
  output logic   busy
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} fsmE;
  fsmE cur, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) cur <= S_IDLE;
    else       cur <= nxt;
  end

  always_comb begin
    strobe = '0;
    nxt    = cur;
    unique case (cur)
      S_IDLE: if (reqValid) begin
        strobe.latchReq = 1'b1;
        nxt = S_LOOK;
      end
      S_LOOK: begin
        strobe.lookupCommit = 1'b1;
        nxt = needFwd ? S_WAIT : S_IDLE;
      end
      S_WAIT: if (ackValid) begin
        strobe.ackCommit = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (cur != S_IDLE);

endmodule

// File: rtl/snoopdir_dp.sv
module snoopdir_dp
  import snoopdir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int INDEX_W   = 3,
  localparam int CORE_W   = $clog2(NUM_CORES)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobe,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 needFwd,
  output logic                 rspValid,
  output logic [2:0]           rspKind,
  output logic [CORE_W-1:0]    rspCore,
  output logic [NUM_CORES-1:0] rspDest,
  output logic [NUM_CORES-1:0] rspVictim
);

  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int DEPTH = 1 << INDEX_W;

  logic [TAG_W-1:0]     tagArr  [DEPTH];
  stE                   stArr   [DEPTH];
  logic [NUM_CORES-1:0] presArr [DEPTH];

  // latched request
  logic [CORE_W-1:0] qCore;
  opE                qOp;
  logic [ADDR_W-1:0] qAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCore <= '0;
      qOp   <= OP_READ;
      qAddr <= '0;
    end else if (strobe.latchReq) begin
      qCore <= reqCore;
      qOp   <= opE'(reqOp);
      qAddr <= reqAddr;
    end
  end

  logic [INDEX_W-1:0]   qIdx;
  logic [TAG_W-1:0]     qTag;
  stE                   eSt, curSt, newSt;
  logic [NUM_CORES-1:0] ePres, curPres, newPres, reqBit, others;
  logic [NUM_CORES-1:0] destC, victimC;
  logic                 live, hit, ownerElse, wrNow, fwdC;
  rkE                   kindC;

  assign qIdx    = qAddr[INDEX_W-1:0];
  assign qTag    = qAddr[ADDR_W-1:INDEX_W];
  assign eSt     = stArr[qIdx];
  assign ePres   = presArr[qIdx];
  assign live    = (eSt != ST_INV);
  assign hit     = live && (tagArr[qIdx] == qTag);
  assign curSt   = hit ? eSt : ST_INV;
  assign curPres = hit ? ePres : '0;
  assign reqBit  = NUM_CORES'(1) << qCore;
  assign others  = curPres & ~reqBit;
  assign ownerElse = (curSt == ST_MOD) && !curPres[qCore];

  always_comb begin
    kindC   = RK_DONE;
    destC   = '0;
    victimC = '0;
    wrNow   = 1'b0;
    fwdC    = 1'b0;
    newSt   = curSt;
    newPres = curPres;
    unique case (qOp)
      OP_EVICT: begin
        if (hit) begin
          wrNow   = 1'b1;
          newPres = curPres & ~reqBit;
          newSt   = (newPres == '0) ? ST_INV : curSt;
        end
      end
      OP_READ: begin
        victimC = (live && !hit) ? ePres : '0;
        if (ownerElse) begin
          kindC   = RK_FWD_RD;
          destC   = curPres;
          fwdC    = 1'b1;
          newSt   = ST_SHR;
          newPres = curPres | reqBit;
        end else if (curSt == ST_MOD) begin
          kindC = RK_GRANT_M;
        end else begin
          kindC   = RK_GRANT_S;
          wrNow   = 1'b1;
          newSt   = ST_SHR;
          newPres = curPres | reqBit;
        end
      end
      default: begin
        victimC = (live && !hit) ? ePres : '0;
        newSt   = ST_MOD;
        newPres = reqBit;
        if (ownerElse) begin
          kindC = RK_FWD_WR;
          destC = curPres;
          fwdC  = 1'b1;
        end else begin
          kindC = RK_GRANT_M;
          destC = others;
          wrNow = 1'b1;
        end
      end
    endcase
  end

  assign needFwd = fwdC;

  // update held until the owner acknowledges
  stE                   pendSt;
  logic [NUM_CORES-1:0] pendPres;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSt   <= ST_INV;
      pendPres <= '0;
    end else if (strobe.lookupCommit) begin
      pendSt   <= newSt;
      pendPres <= newPres;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic selI;
    assign selI = (qIdx == INDEX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagArr[i]  <= '0;
        stArr[i]   <= ST_INV;
        presArr[i] <= '0;
      end else if (selI && strobe.lookupCommit && wrNow) begin
        tagArr[i]  <= qTag;
        stArr[i]   <= newSt;
        presArr[i] <= newPres;
      end else if (selI && strobe.ackCommit) begin
        tagArr[i]  <= qTag;
        stArr[i]   <= pendSt;
        presArr[i] <= pendPres;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspKind   <= '0;
      rspCore   <= '0;
      rspDest   <= '0;
      rspVictim <= '0;
    end else begin
      rspValid <= strobe.lookupCommit;
      if (strobe.lookupCommit) begin
        rspKind   <= kindC;
        rspCore   <= qCore;
        rspDest   <= destC;
        rspVictim <= victimC;
      end
    end
  end

endmodule

// File: rtl/snoopdir.sv
module snoopdir
  import snoopdir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int INDEX_W   = 3,
  localparam int CORE_W   = $clog2(NUM_CORES)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 ackValid,
  output logic                 busy,
  output logic                 rspValid,
  output logic [2:0]           rspKind,
  output logic [CORE_W-1:0]    rspCore,
  output logic [NUM_CORES-1:0] rspDest,
  output logic [NUM_CORES-1:0] rspVictim
);

  strobeT strobe;
  logic   needFwd;

  snoopdir_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needFwd(needFwd),
    .ackValid(ackValid), .strobe(strobe), .busy(busy)
  );

  snoopdir_dp #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCore(reqCore), .reqOp(reqOp),
    .reqAddr(reqAddr), .needFwd(needFwd), .rspValid(rspValid), .rspKind(rspKind),
    .rspCore(rspCore), .rspDest(rspDest), .rspVictim(rspVictim)
  );

endmodule

// File: rtl/snoopdir_chk.sv
module snoopdir_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int INDEX_W   = 3,
  localparam int CORE_W   = $clog2(NUM_CORES)
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [CORE_W-1:0]    reqCore,
  input logic [1:0]           reqOp,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic                 ackValid,
  input logic                 busy,
  input logic                 rspValid,
  input logic [2:0]           rspKind,
  input logic [CORE_W-1:0]    rspCore,
  input logic [NUM_CORES-1:0] rspDest,
  input logic [NUM_CORES-1:0] rspVictim
);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_after_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busy));

  p_fwd_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspKind == 3'd2 || rspKind == 3'd3)) |-> ($countones(rspDest) == 1));

  p_fwd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspKind == 3'd2 || rspKind == 3'd3)) |-> busy);

  p_grant_s_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd0) |-> (rspDest == '0));

  p_evict_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd4) |-> (rspDest == '0 && rspVictim == '0));

  p_no_self_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !rspDest[rspCore]);

endmodule

bind snoopdir snoopdir_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) chk_i (.*);

// File: tb/snoopdir_tb_top.sv
`timescale 1ns/1ps
module snoopdir_tb_top;

  localparam int NC    = 4;
  localparam int AW    = 10;
  localparam int IW    = 3;
  localparam int DEPTH = 1 << IW;
  localparam int K_GS = 0, K_GM = 1, K_FR = 2, K_FW = 3, K_DN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCore = '0;
  logic [1:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic ackValid = 1'b0;
  logic busy, rspValid;
  logic [2:0] rspKind;
  logic [1:0] rspCore;
  logic [NC-1:0] rspDest, rspVictim;

  always #2 clk = ~clk;

  snoopdir #(.NUM_CORES(NC), .ADDR_W(AW), .INDEX_W(IW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCore(reqCore), .reqOp(reqOp),
    .reqAddr(reqAddr), .ackValid(ackValid), .busy(busy), .rspValid(rspValid),
    .rspKind(rspKind), .rspCore(rspCore), .rspDest(rspDest), .rspVictim(rspVictim)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference directory
  int mSt[DEPTH];
  int mTag[DEPTH];
  int mPres[DEPTH];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReq(input int core, input int op, input int addr, input string req, input int ackDelay);
    int idx, t, cs, cp, rb, eKind, eDest, eVic, nSt, nPres;
    bit live, hit, fwd, wr;
    idx = addr % DEPTH; t = addr / DEPTH; rb = 1 << core;
    live = (mSt[idx] != 0); hit = live && (mTag[idx] == t);
    cs = hit ? mSt[idx] : 0; cp = hit ? mPres[idx] : 0;
    eDest = 0; eVic = 0; fwd = 0; wr = 0; nSt = cs; nPres = cp; eKind = K_DN;
    if (op == 3) begin
      if (hit) begin wr = 1; nPres = cp & ~rb; nSt = (nPres == 0) ? 0 : cs; end
    end else begin
      if (live && !hit) eVic = mPres[idx];
      if (cs == 2 && (cp & rb) == 0) begin
        fwd = 1; wr = 1; eDest = cp;
        eKind = (op == 0) ? K_FR : K_FW;
        nSt = (op == 0) ? 1 : 2; nPres = (op == 0) ? (cp | rb) : rb;
      end else if (cs == 2) begin
        eKind = K_GM;
      end else if (op == 0) begin
        eKind = K_GS; wr = 1; nSt = 1; nPres = cp | rb;
      end else begin
        eKind = K_GM; wr = 1; nSt = 2; nPres = rb; eDest = cp & ~rb;
      end
    end
    if (wr) begin mSt[idx] = nSt; mTag[idx] = t; mPres[idx] = nPres; end

    @(negedge clk);
    reqValid = 1'b1; reqCore = 2'(core); reqOp = 2'(op); reqAddr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    chk(rspValid == 1'b0, "R9", "no early response", int'(rspValid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(rspValid == 1'b1, "R9", "response pulse", int'(rspValid), 1);
    chk(int'(rspKind) == eKind, req, "kind", int'(rspKind), eKind);
    chk(int'(rspDest) == eDest, req, "dest mask", int'(rspDest), eDest);
    chk(int'(rspVictim) == eVic, req, "victim mask", int'(rspVictim), eVic);
    chk(int'(rspCore) == core, "R10", "requester", int'(rspCore), core);
    chk(busy == fwd, req, "busy after response", int'(busy), int'(fwd));
    if (fwd) begin
      for (int i = 0; i < ackDelay; i++) begin
        reqValid = 1'b1; reqCore = 2'((core + 1) % NC); reqOp = 2'd1; reqAddr = AW'(addr);
        @(posedge clk);
        @(negedge clk);
        chk(rspValid == 1'b0 && busy == 1'b1, "R9", "ignored while waiting", int'(rspValid), 0);
      end
      reqValid = 1'b0;
      ackValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ackValid = 1'b0;
      chk(busy == 1'b0, req, "busy cleared by ack", int'(busy), 0);
      chk(rspValid == 1'b0, "R9", "no extra response", int'(rspValid), 0);
    end
    @(negedge clk);
    chk(rspValid == 1'b0, "R9", "idle quiet", int'(rspValid), 0);
  endtask

  localparam int A_ = 5*8 + 1;
  localparam int B_ = 9*8 + 1;
  localparam int C_ = 3*8 + 2;
  localparam int D_ = 12*8 + 1;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mSt[i] = 0; mTag[i] = 0; mPres[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(busy == 1'b0, "R9", "reset busy", int'(busy), 0);
    chk(rspValid == 1'b0, "R9", "reset rspValid", int'(rspValid), 0);

    doReq(0, 0, A_, "R1", 0);
    doReq(1, 0, A_, "R1", 0);
    doReq(2, 0, A_, "R1", 0);
    doReq(1, 2, A_, "R3", 0);   // invalidates cores 0 and 2
    doReq(3, 0, A_, "R2", 3);   // forward read to core 1
    doReq(0, 1, A_, "R3", 0);   // invalidates cores 1 and 3
    doReq(2, 1, A_, "R4", 2);   // forward write to core 0
    doReq(2, 1, A_, "R5", 0);
    doReq(2, 0, A_, "R5", 0);
    doReq(1, 0, B_, "R8", 0);   // displaces A held by core 2
    doReq(1, 3, A_, "R7", 0);   // A no longer tracked
    doReq(0, 0, B_, "R1", 0);
    doReq(3, 2, B_, "R3", 0);   // proves R7 left B intact: dest {0,1}
    doReq(0, 0, C_, "R1", 0);
    doReq(0, 3, C_, "R6", 0);   // last holder leaves
    doReq(1, 0, C_ + 8, "R6", 0); // same entry, nothing displaced
    doReq(3, 3, B_, "R6", 0);   // owner evicts B
    doReq(2, 1, D_, "R6", 0);   // entry free, no victim
    doReq(1, 0, D_, "R2", 1);
    doReq(2, 3, D_, "R6", 0);
    doReq(0, 1, D_, "R3", 0);   // only core 1 remains to invalidate

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule